// File: doc/BRIEF.md
# Gated Duty-Ratio Converter Drive

This block generates two independent pulse trains for switching power converters. One phase counter is shared by both outputs. It advances on a tick enable that runs at sixteen times the output rate, so a 1.536 MHz tick gives a 96 kHz output period. Each output has a 4-bit duty setting. A setting of N drives the output high for the first N of the sixteen steps of a period and low for the rest. A setting of zero keeps the output low.

Each output is also gated by its own asynchronous feedback input. That input is normally a comparator that watches the converter's output voltage. Each feedback input passes through a two-flop synchronizer. The synchronized value is sampled only at the start of a period, so a change on the comparator never cuts a pulse short and never starts a partial pulse. The duty settings are also taken only at the start of a period, so a period is never built from two different settings.

All pins are plain control or level signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. The duty inputs may change at any time and are simply sampled at the next period start.

Top module: `dcdc_drive_gen`

## Requirements
- R1: The shared phase counter advances by one step on each clock edge with `step_tick` high and wraps from 15 to 0. A new period starts on the tick that moves the phase from 15 to 0, so one output period is exactly 16 ticks.
- R2: With a latched duty N (1 to 14) and the output enabled, the output is high during phases 0 to N-1 of the period and low during phases N to 15.
- R3: A latched duty of 0 holds the output low for the whole period.
- R4: A latched duty of 15 drives the output high for phases 0 to 14 and low in phase 15, so the output is never on for a whole period.
- R5: Each feedback input passes through two synchronizing flops. The synchronized value is captured only at the period-start tick, and feedback changes at any other time have no effect on the current period.
- R6: If the captured enable is low, the output stays low for the whole period, whatever the duty setting.
- R7: A duty input is captured only at the period-start tick. Changes at any other time do not alter the current period.
- R8: The two channels are independent. The duty and feedback of one channel never affect the other channel's output.
- R9: While `rst_n` is low, both outputs are low and the phase is 0. After reset, both outputs stay low until the first period start that captures a nonzero duty with the enable high.
- R10: In a cycle with `step_tick` low, the phase and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_tick | input | 1 | Step enable at 16x the output rate |
| duty_a | input | 4 | Duty setting of channel A, in sixteenths of a period |
| duty_b | input | 4 | Duty setting of channel B, in sixteenths of a period |
| fb_a | input | 1 | Asynchronous feedback enable of channel A |
| fb_b | input | 1 | Asynchronous feedback enable of channel B |
| drv_a | output | 1 | Drive output of channel A |
| drv_b | output | 1 | Drive output of channel B |

## Verification
The bench targets feedback and duty changes that arrive in the middle of a period. A design that sampled them early would cut a pulse short or start a partial pulse, and a design that skipped a synchronizer stage would react one period too early when an edge lands just before the wrap. It sweeps every duty value, including 0, which must never pulse, and 15, which must drop for exactly the last step. An off-by-one comparison there would show a pulse that is one step too long or too short. Long gaps between ticks catch a counter that runs freely. Opposite settings on the two channels catch logic where one channel's state leaks into the other.

// File: rtl/dcdc_pkg.sv
package dcdc_pkg;
  localparam int unsigned STEPS  = 16;
  localparam int unsigned PH_W   = $clog2(STEPS);
  localparam int unsigned DUTY_W = PH_W;
  localparam int unsigned NCH    = 2;

  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [DUTY_W-1:0] duty_t;

  // Output level for one step: high while the phase is below the duty.
  function automatic logic level_at(phase_t ph, duty_t duty, logic en);
    return en && (ph < duty);
  endfunction
endpackage

// File: rtl/dcdc_phase_ctr.sv
module dcdc_phase_ctr
  import dcdc_pkg::*;
#(
  parameter int unsigned N_STEPS = STEPS
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  output phase_t ph,
  output phase_t ph_nxt,
  output logic   wrap
);
  localparam phase_t LAST = phase_t'(N_STEPS - 1);

  logic at_last;

  assign at_last = (ph == LAST);
  assign wrap    = tick && at_last;
  assign ph_nxt  = at_last ? '0 : ph + phase_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (tick) begin
      ph <= ph_nxt;
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ph));

  // R1
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (ph != $past(ph)));
endmodule

// File: rtl/dcdc_fb_sync.sv
module dcdc_fb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
    end else begin
      sh <= {sh[STAGES-2:0], d};
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dcdc_chan.sv
module dcdc_chan
  import dcdc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   wrap,
  input  phase_t ph,
  input  phase_t ph_nxt,
  input  duty_t  duty_in,
  input  logic   en_in,
  output logic   drv
);
  duty_t duty_q;
  logic  en_q;
  logic  drv_q;
  duty_t nxt_duty;
  logic  nxt_en;

  // Values that hold during the step that the coming tick opens.
  assign nxt_duty = wrap ? duty_in : duty_q;
  assign nxt_en   = wrap ? en_in   : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
      en_q   <= 1'b0;
      drv_q  <= 1'b0;
    end else if (tick) begin
      if (wrap) begin
        duty_q <= duty_in;
        en_q   <= en_in;
      end
      drv_q <= level_at(ph_nxt, nxt_duty, nxt_en);
    end
  end

  assign drv = drv_q;

  // R3
  duty_zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !drv_q);

  // R6
  gate_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !drv_q);

  // R2
  on_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> (ph < duty_q));

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(en_q));
endmodule

// File: rtl/dcdc_drive_gen.sv
module dcdc_drive_gen
  import dcdc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_tick,
  input  logic [DUTY_W-1:0] duty_a,
  input  logic [DUTY_W-1:0] duty_b,
  input  logic              fb_a,
  input  logic              fb_b,
  output logic              drv_a,
  output logic              drv_b
);
  phase_t ph;
  phase_t ph_nxt;
  logic   wrap;

  duty_t          duty_v [NCH];
  logic [NCH-1:0] fb_v;
  logic [NCH-1:0] en_s;
  logic [NCH-1:0] drv_v;

  assign duty_v[0] = duty_a;
  assign duty_v[1] = duty_b;
  assign fb_v      = {fb_b, fb_a};

  dcdc_phase_ctr #(.N_STEPS(STEPS)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (step_tick),
    .ph     (ph),
    .ph_nxt (ph_nxt),
    .wrap   (wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcdc_fb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fb_v[c]),
      .q     (en_s[c])
    );

    dcdc_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (step_tick),
      .wrap    (wrap),
      .ph      (ph),
      .ph_nxt  (ph_nxt),
      .duty_in (duty_v[c]),
      .en_in   (en_s[c]),
      .drv     (drv_v[c])
    );
  end

  assign drv_a = drv_v[0];
  assign drv_b = drv_v[1];

  // R9
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!drv_a && !drv_b && (ph == '0)));
endmodule

// File: tb/sim_dcdc_drive_gen.sv
module sim_dcdc_drive_gen;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] da = '0;
  logic [3:0] db = '0;
  logic       fa = 1'b0;
  logic       fb = 1'b0;
  logic       drv_a;
  logic       drv_b;

  int    checks = 0;
  int    errors = 0;
  int    cyc_cnt = 0;
  bit    done = 1'b0;
  string sec_tag = "";

  // Reference state, built from the requirements.
  logic [3:0] m_ph;
  logic [3:0] m_duty [2];
  logic       m_en [2];
  logic       m_s1 [2];
  logic       m_s2 [2];

  always #2 clk = ~clk;

  dcdc_drive_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_tick (tick),
    .duty_a    (da),
    .duty_b    (db),
    .fb_a      (fa),
    .fb_b      (fb),
    .drv_a     (drv_a),
    .drv_b     (drv_b)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= '0;
      for (int c = 0; c < 2; c++) begin
        m_duty[c] <= '0; m_en[c] <= 1'b0; m_s1[c] <= 1'b0; m_s2[c] <= 1'b0;
      end
    end else begin
      m_s1[0] <= fa; m_s2[0] <= m_s1[0];
      m_s1[1] <= fb; m_s2[1] <= m_s1[1];
      if (tick) begin
        if (m_ph == 4'd15) begin
          m_duty[0] <= da; m_en[0] <= m_s2[0];
          m_duty[1] <= db; m_en[1] <= m_s2[1];
        end
        m_ph <= m_ph + 4'd1;
      end
    end
  end

  function automatic logic exp_level(int c);
    if (!rst_n) return 1'b0;
    return m_en[c] && (m_ph < m_duty[c]);
  endfunction

  function automatic string auto_tag(int c);
    if (!rst_n) return "R9";
    if (m_duty[c] == 4'd0) return "R3";
    if (!m_en[c]) return "R6";
    if (m_duty[c] == 4'd15) return "R4";
    return "R2";
  endfunction

  task automatic check_outputs();
    for (int c = 0; c < 2; c++) begin
      logic  got;
      logic  exp;
      string tg;
      got = (c == 0) ? drv_a : drv_b;
      exp = exp_level(c);
      tg  = (sec_tag != "") ? sec_tag : auto_tag(c);
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s ch%0d phase %0d: drv=%0b expected %0b", tg, c, m_ph, got, exp);
      end
    end
  endtask

  task automatic cyc(input logic t, input logic [3:0] a, input logic [3:0] b,
                     input logic f0, input logic f1);
    @(negedge clk);
    check_outputs();
    tick = t; da = a; db = b; fa = f0; fb = f1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt >= WD_LIMIT && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected end before %0d", cyc_cnt, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1d5e_ed42);

    // R9: reset holds outputs low, even with inputs active
    sec_tag = "R9";
    rst_n = 1'b0;
    for (int i = 0; i < 6; i++) cyc(1'b1, 4'd9, 4'd9, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    // first period after reset: enable not yet captured, outputs low
    for (int i = 0; i < 16; i++) cyc(1'b1, 4'd9, 4'd9, 1'b1, 1'b1);

    // R1: continuous ticks, periods of exactly 16 steps
    sec_tag = "R1";
    for (int i = 0; i < 16 * 40; i++) cyc(1'b1, 4'd5, 4'd11, 1'b1, 1'b1);

    // R2: sweep of every middle duty, tick every second cycle
    sec_tag = "R2";
    for (int d = 1; d <= 14; d++)
      for (int i = 0; i < 2 * 16 * 2; i++)
        cyc(i[0], 4'(d), 4'(15 - d), 1'b1, 1'b1);

    // R3: zero duty never pulses
    sec_tag = "R3";
    for (int i = 0; i < 16 * 4; i++) cyc(1'b1, 4'd0, 4'd0, 1'b1, 1'b1);

    // R4: full-scale duty drops in the last step
    sec_tag = "R4";
    for (int i = 0; i < 16 * 4; i++) cyc(1'b1, 4'd15, 4'd15, 1'b1, 1'b1);

    // R7: duty inputs change every cycle, only period-start value counts
    sec_tag = "R7";
    for (int i = 0; i < 16 * 50; i++)
      cyc(1'b1, 4'($urandom), 4'($urandom), 1'b1, 1'b1);

    // R6: feedback low gates the output off
    sec_tag = "R6";
    for (int i = 0; i < 16 * 5; i++) cyc(1'b1, 4'd9, 4'd12, 1'b0, 1'b0);

    // R5: short feedback glitches mid-period, then random toggling
    sec_tag = "R5";
    for (int p = 0; p < 20; p++)
      for (int i = 0; i < 16; i++)
        cyc(1'b1, 4'd8, 4'd8, (i == 6), (i == 12) || (i == 13));
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 3) != 0, 4'd8, 4'd3, ($urandom % 4) == 0, ($urandom % 2) == 0);

    // R10: sparse ticks, long holds between steps
    sec_tag = "R10";
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 8) == 0, 4'($urandom), 4'($urandom), 1'b1, ($urandom % 16) != 0);
    for (int i = 0; i < 40; i++) cyc(1'b0, 4'd15, 4'd15, 1'b0, 1'b0);

    // R8: one channel enabled, the other disabled, swapped halfway
    sec_tag = "R8";
    for (int i = 0; i < 16 * 20; i++) cyc(1'b1, 4'd13, 4'd2, 1'b1, 1'b0);
    for (int i = 0; i < 16 * 20; i++) cyc(1'b1, 4'd1, 4'd14, 1'b0, 1'b1);

    // mixed random traffic, tag chosen from the expected situation
    sec_tag = "";
    for (int i = 0; i < 8000; i++)
      cyc(($urandom % 2) == 0, 4'($urandom), 4'($urandom),
          ($urandom % 5) != 0, ($urandom % 3) != 0);

    @(negedge clk);
    check_outputs();
    finish_run();
  end
endmodule